// File: doc/BRIEF.md
# SPI Master with Per-Word Control

This block is an SPI bus master that drains a small transmit queue. Each queue entry packs a data word together with control bits, and those bits decide how that one word goes out on the wire: how many bits it has, which of the four chip-select lines it drives, whether the selects are released after it, and whether the bits clocked in from the slave are kept. Because the control travels with every word, a transaction can mix word lengths, and words chained without a release form frames of any length.

The master drives the serial clock, the outgoing data line and four chip-select lines, and samples the incoming data line. Clock polarity and phase select one of the four usual SPI modes. The serial clock half-period is a configurable number of system clocks. Each select line has its own active level. Received words go into a receive queue, right-aligned to the word length. If that queue has no room, the master waits before it starts any word that would need it.

Top module: `spi_wc_master`

## Requirements
- R1: A word's bit count is the 4-bit entry field [19:16] plus one, so any length from 1 to 16 bits is sent, with exactly twice that many serial clock edges.
- R2: Entries are taken in write order and their data field [15:0] is shifted out most significant bit first, starting at bit (length-1).
- R3: With `cfg_cpol` low the clock idles low, and with it high the clock idles high. With `cfg_cpha` low the incoming data is sampled on the leading edge and the outgoing data changes on the trailing edge. With it high the outgoing data changes on the leading edges (from the second one on) and the incoming data is sampled on the trailing edge.
- R4: Each serial clock half-period lasts `cfg_half` system clocks, so the clock period is 2*`cfg_half` system clocks (a value of 0 acts as 1).
- R5: The entry field [23:20] chooses the select lines of a word. A chosen line is driven to its `cfg_ss_pol` bit (1 = active high) from the load of the word until the word ends. Every other line rests at the inverse of its `cfg_ss_pol` bit.
- R6: When entry bit 24 is set, the selects go inactive after the word's last edge, and the master stays busy for one more half-period before the next word. When bit 24 is clear, the selects stay asserted and the next word follows with no release.
- R7: If the transmit queue is empty after a word with bit 24 clear, the master holds with the selects asserted and the clock at its idle level until an entry arrives.
- R8: Each received word is pushed to the receive queue in arrival order, right-aligned to the word length with the upper bits zero.
- R9: When entry bit 26 is set, the word is transmitted and nothing is pushed to the receive queue. Bit 25 has no effect.
- R10: A word with bit 26 clear does not start while the receive queue is full. It starts once an entry is read from the queue, and no received word is ever lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase select |
| cfg_half | input | 8 | Serial clock half-period in system clocks |
| cfg_ss_pol | input | 4 | Active level of each select line |
| tx_wr | input | 1 | Write strobe for the transmit queue |
| tx_entry | input | 27 | Transmit entry: data, length-1, select mask, release, marker, ignore |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Read strobe for the receive queue |
| rx_data | output | 16 | Oldest received word (valid when not empty) |
| rx_empty | output | 1 | Receive queue empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| ss_out | output | 4 | Select lines |
| busy | output | 1 | A word is in flight, held, or in its release gap |

## Verification
A behavioural slave in the bench captures the outgoing line and shifts a fixed 32-bit pattern back. This lets each word be checked on both sides at once. Single words in all four clock modes at lengths 1, 8, 12 and 16 separate shifting-edge faults from sampling-edge faults, and separate faults in left alignment on transmit from faults in right alignment on receive. A two-word chain with a held stall between the words tells a correct select release apart from an early one. A run that fills the receive queue and then offers one more word shows whether the master waits or drops data. A mixed mask and polarity pattern checks every select lane on its own.

// File: rtl/spi_wc_pkg.sv
package spi_wc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2,
      ST_GAP  = 2'd3
   } eng_state_t;

endpackage

// File: rtl/spi_wc_fifo.sv
module spi_wc_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp, rp, wp_n, rp_n;
   logic [CW-1:0]    cnt;
   logic             do_wr, do_rd;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_wr   = wr && !full;
   assign do_rd   = rd && !empty;
   assign rd_data = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_wrap
         assign wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_wr) wp <= wp_n;
         if (do_rd) rp <= rp_n;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH)); // R10
   AST_FIFO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && !do_rd) |=> !empty); // R8
endmodule

// File: rtl/spi_wc_tick.sv
module spi_wc_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = en && (({1'b0, cnt} + 1'b1) >= {1'b0, half});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   AST_TICK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en && half != '0) |-> (cnt < half)); // R4
endmodule

// File: rtl/spi_wc_engine.sv
module spi_wc_engine
   import spi_wc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NUM_SS = 4,
   localparam int LEN_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [LEN_W-1:0]  tx_len_m1,
   input  logic [NUM_SS-1:0] tx_sel,
   input  logic              tx_eot,
   input  logic              tx_ign,
   input  logic              rx_full,
   input  logic              miso,
   input  logic              tick,
   output logic              tick_en,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_word,
   output logic              sck_t,
   output logic              mosi,
   output logic              ss_act,
   output logic [NUM_SS-1:0] sel_q,
   output logic              busy
);
   localparam int EC_W = LEN_W + 1;

   eng_state_t        st;
   logic [DATA_W-1:0] sh_q, rx_q, rx_next;
   logic [LEN_W-1:0]  len_q;
   logic [EC_W-1:0]   ecnt;
   logic              eot_q, ign_q;
   logic              can_start, load, leading, last_edge;
   logic              run_tick, sample_now, shift_now;

   assign can_start  = tx_valid && (tx_ign || !rx_full);
   assign load       = (st == ST_IDLE || st == ST_HOLD) && can_start;
   assign tx_pop     = load;
   assign tick_en    = (st == ST_RUN) || (st == ST_GAP);
   assign busy       = (st != ST_IDLE);
   assign leading    = !ecnt[0];
   assign last_edge  = (ecnt == {len_q, 1'b1});
   assign run_tick   = tick && (st == ST_RUN);
   assign sample_now = run_tick && (cpha ? !leading : leading);
   assign shift_now  = run_tick && (cpha ? (leading && ecnt != '0) : !leading);
   assign rx_next    = sample_now ? {rx_q[DATA_W-2:0], miso} : rx_q;
   assign rx_push    = run_tick && last_edge && !ign_q;
   assign rx_word    = rx_next;
   assign mosi       = sh_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sh_q   <= '0;
         rx_q   <= '0;
         len_q  <= '0;
         ecnt   <= '0;
         sel_q  <= '0;
         eot_q  <= 1'b0;
         ign_q  <= 1'b0;
         sck_t  <= 1'b0;
         ss_act <= 1'b0;
      end else begin
         case (st)
            ST_IDLE, ST_HOLD: begin
               if (load) begin
                  sh_q   <= tx_data << (LEN_W'(DATA_W - 1) - tx_len_m1);
                  rx_q   <= '0;
                  len_q  <= tx_len_m1;
                  ecnt   <= '0;
                  sel_q  <= tx_sel;
                  eot_q  <= tx_eot;
                  ign_q  <= tx_ign;
                  sck_t  <= 1'b0;
                  ss_act <= 1'b1;
                  st     <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  sck_t <= ~sck_t;
                  ecnt  <= ecnt + 1'b1;
                  rx_q  <= rx_next;
                  if (shift_now) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
                  if (last_edge) begin
                     if (eot_q) begin
                        ss_act <= 1'b0;
                        st     <= ST_GAP;
                     end else begin
                        st     <= ST_HOLD;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_RX_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !rx_full); // R10
   AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) |-> (ecnt <= {len_q, 1'b1})); // R1
   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && $past(st) == ST_RUN) |-> ($stable(sel_q) && ss_act)); // R5
   AST_HOLD_IDLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> (!sck_t && ss_act)); // R7
   AST_IDLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> (!sck_t && !ss_act)); // R3
endmodule

// File: rtl/spi_wc_master.sv
module spi_wc_master #(
   parameter int DATA_W     = 16,
   parameter int NUM_SS     = 4,
   parameter int FIFO_DEPTH = 4,
   parameter int DIV_W      = 8,
   localparam int LEN_W     = $clog2(DATA_W),
   localparam int ENTRY_W   = DATA_W + LEN_W + NUM_SS + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_cpol,
   input  logic               cfg_cpha,
   input  logic [DIV_W-1:0]   cfg_half,
   input  logic [NUM_SS-1:0]  cfg_ss_pol,
   input  logic               tx_wr,
   input  logic [ENTRY_W-1:0] tx_entry,
   output logic               tx_full,
   input  logic               rx_rd,
   output logic [DATA_W-1:0]  rx_data,
   output logic               rx_empty,
   output logic               sck,
   output logic               mosi,
   input  logic               miso,
   output logic [NUM_SS-1:0]  ss_out,
   output logic               busy
);
   localparam int LEN_LSB = DATA_W;
   localparam int SEL_LSB = LEN_LSB + LEN_W;
   localparam int EOT_BIT = SEL_LSB + NUM_SS;
   localparam int IGN_BIT = EOT_BIT + 2;

   generate
      if (DATA_W < 2)     begin : g_bad_w   $error("DATA_W must be at least 2"); end
      if (NUM_SS < 1)     begin : g_bad_ss  $error("NUM_SS must be at least 1"); end
      if (FIFO_DEPTH < 2) begin : g_bad_dep $error("FIFO_DEPTH must be at least 2"); end
      if (DIV_W < 1)      begin : g_bad_div $error("DIV_W must be at least 1"); end
   endgenerate

   logic [ENTRY_W-1:0] head;
   logic               tx_empty, tx_pop, rx_push, rx_full;
   logic [DATA_W-1:0]  rx_word;
   logic               tick, tick_en, sck_t, ss_act;
   logic [NUM_SS-1:0]  sel_q;

   spi_wc_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wr_data(tx_entry),
      .rd(tx_pop), .rd_data(head), .full(tx_full), .empty(tx_empty));

   spi_wc_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .wr(rx_push), .wr_data(rx_word),
      .rd(rx_rd), .rd_data(rx_data), .full(rx_full), .empty(rx_empty));

   spi_wc_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(tick_en), .half(cfg_half), .tick(tick));

   spi_wc_engine #(.DATA_W(DATA_W), .NUM_SS(NUM_SS)) u_eng (
      .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha),
      .tx_valid(!tx_empty),
      .tx_data(head[DATA_W-1:0]),
      .tx_len_m1(head[SEL_LSB-1:LEN_LSB]),
      .tx_sel(head[EOT_BIT-1:SEL_LSB]),
      .tx_eot(head[EOT_BIT]),
      .tx_ign(head[IGN_BIT]),
      .rx_full(rx_full), .miso(miso), .tick(tick), .tick_en(tick_en),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
      .sck_t(sck_t), .mosi(mosi), .ss_act(ss_act), .sel_q(sel_q), .busy(busy));

   assign sck = sck_t ^ cfg_cpol;

   generate
      for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
         assign ss_out[i] = (ss_act && sel_q[i]) ? cfg_ss_pol[i] : ~cfg_ss_pol[i];
      end
   endgenerate

   AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> !tx_empty); // R2
endmodule

// File: tb/spi_wc_master_tb.sv
module spi_wc_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [7:0]  cfg_half = 8'd2;
   logic [3:0]  cfg_ss_pol = 4'b0000;
   logic        tx_wr = 1'b0;
   logic [26:0] tx_entry = '0;
   logic        tx_full;
   logic        rx_rd = 1'b0;
   logic [15:0] rx_data;
   logic        rx_empty;
   logic        sck, mosi, miso;
   logic [3:0]  ss_out;
   logic        busy;

   int checks = 0, failures = 0;
   bit done = 0;

   logic [31:0] pat = 32'hC3A5_9E17;
   logic [31:0] cap;
   int          scnt;
   int          rel_cnt;

   always #5 clk = ~clk;

   spi_wc_master u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_half(cfg_half), .cfg_ss_pol(cfg_ss_pol), .tx_wr(tx_wr),
      .tx_entry(tx_entry), .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data),
      .rx_empty(rx_empty), .sck(sck), .mosi(mosi), .miso(miso),
      .ss_out(ss_out), .busy(busy));

   // behavioural slave
   assign miso = (scnt < 32) ? pat[31 - scnt] : 1'b0;
   always @(posedge sck) if (cfg_cpol == cfg_cpha) begin cap = {cap[30:0], mosi}; scnt++; end
   always @(negedge sck) if (cfg_cpol != cfg_cpha) begin cap = {cap[30:0], mosi}; scnt++; end
   always @(ss_out[0]) if (ss_out[0] == ~cfg_ss_pol[0]) rel_cnt++;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic slave_reset();
      #1; scnt = 0; cap = '0; rel_cnt = 0;
   endtask

   function automatic logic [26:0] mk(input logic [15:0] d, input int len,
                                      input logic [3:0] mask, input bit eot, input bit ign);
      logic [3:0] lm1 = 4'(len - 1);
      return {ign, 1'b0, eot, mask, lm1, d};
   endfunction

   task automatic push(input logic [26:0] e);
      @(negedge clk); tx_entry = e; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic pop_chk(input logic [15:0] exp, input string tag);
      @(negedge clk);
      chk(!rx_empty, {tag, " rx not empty"}, {31'd0, rx_empty}, 32'd0);
      chk(rx_data == exp, {tag, " rx word"}, {16'd0, rx_data}, {16'd0, exp});
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
   endtask

   task automatic set_mode(input bit pol, input bit pha, input logic [7:0] half);
      @(negedge clk); cfg_cpol = pol; cfg_cpha = pha; cfg_half = half;
      slave_reset();
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(ss_out == 4'hF, "R5 reset select idle", {28'd0, ss_out}, 32'hF);
      chk(sck == 1'b0, "R3 reset clock idle", {31'd0, sck}, 32'd0);
      chk(!busy, "R6 reset not busy", {31'd0, busy}, 32'd0);
      chk(rx_empty, "R8 reset rx empty", {31'd0, rx_empty}, 32'd1);
   endtask

   task automatic t_basic();
      time t1, t2;
      set_mode(0, 0, 8'd3);
      push(mk(16'h00A5, 8, 4'b0001, 1, 0));
      @(posedge sck) t1 = $time;
      @(posedge sck) t2 = $time;
      chk((t2 - t1) == 60, "R4 clock period", 32'(t2 - t1), 32'd60);
      wait_idle();
      chk(cap[7:0] == 8'hA5, "R2 msb first data", cap, 32'hA5);
      chk(scnt == 8, "R1 eight edges sampled", 32'(scnt), 32'd8);
      chk(ss_out == 4'hF, "R6 select released", {28'd0, ss_out}, 32'hF);
      chk(rel_cnt == 1, "R6 one release", 32'(rel_cnt), 32'd1);
      pop_chk(16'(pat >> 24), "R8 basic");
   endtask

   task automatic t_mode(input bit pol, input bit pha, input int len, input logic [15:0] d);
      logic [15:0] dm = 16'((32'(d) << (32 - len)) >> (32 - len));
      set_mode(pol, pha, 8'd2);
      push(mk(d, len, 4'b0001, 1, 0));
      wait_idle();
      chk(cap[15:0] == dm, $sformatf("R3 mode %0d%0d len %0d tx", pol, pha, len), cap, {16'd0, dm});
      chk(scnt == len, "R1 bit count", 32'(scnt), 32'(len));
      chk(sck == pol, "R3 clock idle level", {31'd0, sck}, {31'd0, pol});
      pop_chk(16'(pat >> (32 - len)), "R8 mode rx");
   endtask

   task automatic t_chain();
      set_mode(0, 0, 8'd2);
      push(mk(16'hBEEF, 16, 4'b0001, 0, 0));
      repeat (100) @(negedge clk);
      chk(busy, "R7 held busy", {31'd0, busy}, 32'd1);
      chk(ss_out[0] == 1'b0, "R7 select held", {31'd0, ss_out[0]}, 32'd0);
      chk(sck == 1'b0, "R7 clock idle in hold", {31'd0, sck}, 32'd0);
      push(mk(16'h1234, 16, 4'b0001, 1, 0));
      wait_idle();
      chk(cap == 32'hBEEF_1234, "R6 chained data", cap, 32'hBEEF_1234);
      chk(rel_cnt == 1, "R6 no release between words", 32'(rel_cnt), 32'd1);
      pop_chk(pat[31:16], "R8 chain first");
      pop_chk(pat[15:0], "R8 chain second");
   endtask

   task automatic t_ignore();
      set_mode(0, 1, 8'd2);
      push(mk(16'h005A, 8, 4'b0001, 1, 1));
      wait_idle();
      chk(cap[7:0] == 8'h5A, "R9 ignored word sent", cap, 32'h5A);
      chk(rx_empty, "R9 nothing pushed", {31'd0, rx_empty}, 32'd1);
   endtask

   task automatic t_rxfull();
      set_mode(1, 0, 8'd1);
      for (int k = 0; k < 4; k++) push(mk(16'(k + 1), 4, 4'b0001, 1, 0));
      wait_idle();
      push(mk(16'h0009, 4, 4'b0001, 1, 0));
      repeat (40) @(negedge clk);
      chk(!busy, "R10 waits on full rx", {31'd0, busy}, 32'd0);
      chk(scnt == 16, "R10 no extra edges", 32'(scnt), 32'd16);
      pop_chk(16'((pat >> 28) & 32'hF), "R10 first");
      wait_idle();
      chk(scnt == 20, "R10 resumed", 32'(scnt), 32'd20);
      for (int k = 1; k < 5; k++) pop_chk(16'((pat >> (28 - 4 * k)) & 32'hF), "R10 order");
      chk(cap[19:0] == 20'h12349, "R2 queue order", cap, 32'h12349);
   endtask

   task automatic t_polarity();
      set_mode(0, 0, 8'd2);
      @(negedge clk); cfg_ss_pol = 4'b0101;
      @(negedge clk);
      chk(ss_out == 4'b1010, "R5 idle levels", {28'd0, ss_out}, 32'hA);
      push(mk(16'h0003, 2, 4'b0110, 1, 1));
      @(posedge sck); @(negedge clk);
      chk(ss_out == 4'b1100, "R5 active levels", {28'd0, ss_out}, 32'hC);
      wait_idle();
      chk(ss_out == 4'b1010, "R5 levels restored", {28'd0, ss_out}, 32'hA);
      @(negedge clk); cfg_ss_pol = 4'b0000;
   endtask

   initial begin
      slave_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mode(0, 1, 16, 16'hC0DE);
      t_mode(1, 0, 1, 16'h0001);
      t_mode(1, 1, 12, 16'h0A5C);
      t_chain();
      t_ignore();
      t_rxfull();
      t_polarity();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule